// File: doc/BRIEF.md
# Offset-Loop Bandwidth Sequencer for Preamble Gain Control

This block is a small digital controller in a low-IF receiver baseband. It runs while automatic gain control works through a short preamble. It drives a 2-bit code that selects the corner of the DC-offset-cancellation high-pass loop. Right after gain control starts, the block selects a wide corner so that the baseband output settles quickly. After a fixed number of baseband clock cycles it selects a medium corner. This corner sits below the passband edge, so the gain measurements remain valid. When the gain loop freezes, it selects a narrow corner that leaves the passband untouched.

At the same time the block marks out the gain-update windows. There are three windows of equal length, each `WIN_CYCLES` clocks long:

- an initial energy-detect setting (G1);
- a coarse step (G2);
- an optional fine step (G3).

At the end of G2, a "level reached" input lets the sequence skip G3. The block ends in a frozen state, which it leaves only when gain control starts again. The freeze input ends any active window at once. A new start at any time restarts the whole sequence.

Top module: `offset_bw_sequencer`

## Requirements
- R1: While reset is active and until the first start, `bw_code_o` is 2'b00, `phase_o` is IDLE (3'd0) and `done_o` is 0.
- R2: A start sampled on a clock edge puts the block, from that edge on, in G1 (`phase_o` = 3'd1) with `bw_code_o` = 2'b11 (wide).
- R3: After a start, 2'b11 is held for exactly `WIDE_CYCLES` (default 36) cycles. Then `bw_code_o` becomes 2'b10 (medium) while a gain window is still active.
- R4: A freeze sampled during G1, G2 or G3 makes the block FROZEN (`phase_o` = 3'd4) from that edge on, with `bw_code_o` = 2'b01 (narrow) and `done_o` = 1.
- R5: The windows follow the order G1 → G2 (3'd2) → G3 (3'd3), each lasting `WIN_CYCLES` (default 32) cycles.
- R6: If `level_ok_i` is high on the last cycle of G2, G3 is skipped and the block goes straight to FROZEN. `level_ok_i` has no effect at any other time.
- R7: At the end of G3 the block becomes FROZEN without waiting for a freeze. The whole sequence therefore fits in three windows.
- R8: FROZEN, with code 2'b01 and `done_o` = 1, is held whatever the freeze and level inputs do, until the next start.
- R9: A start during G1, G2 or G3 restarts the cycle count. The code returns to 2'b11 for a further `WIDE_CYCLES` cycles, and the phase returns to G1.
- R10: Freeze and level inputs in IDLE are ignored: the phase stays IDLE and the code stays 2'b00.
- R11: When start and freeze are sampled on the same edge, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| agc_start_i | input | 1 | Gain control begins (sampled each cycle) |
| agc_freeze_i | input | 1 | Gain control has frozen its setting |
| level_ok_i | input | 1 | Output level reached; sampled on the last G2 cycle |
| bw_code_o | output | 2 | Offset-loop corner: 11 wide, 10 medium, 01 narrow, 00 idle |
| phase_o | output | 3 | 0 IDLE, 1 G1, 2 G2, 3 G3, 4 FROZEN |
| done_o | output | 1 | High in FROZEN |

## Verification
Every output is taken straight from registers, so each result is due exactly one clock edge after the input that causes it is sampled. Counted from the start edge, this gives the following schedule:

- the medium code appears on cycle `WIDE_CYCLES`;
- G2 begins at cycle `WIN_CYCLES`;
- G3 begins at cycle 2·`WIN_CYCLES`;
- FROZEN begins at cycle 3·`WIN_CYCLES`, or at 2·`WIN_CYCLES` when the level input skips G3.

The driver changes inputs just after a falling edge. For each driven cycle it queues the outputs due after the next rising edge. The monitor compares them on the following falling edge, so every comparison lands on exactly the cycle where the result is due.

// File: rtl/obs_pkg.sv
package obs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_G1     = 3'd1,
    PH_G2     = 3'd2,
    PH_G3     = 3'd3,
    PH_FROZEN = 3'd4
  } agc_phase_e;

  typedef enum logic [1:0] {
    BW_OFF    = 2'b00,
    BW_NARROW = 2'b01,
    BW_MEDIUM = 2'b10,
    BW_WIDE   = 2'b11
  } bw_code_e;

  function automatic logic phase_active(input agc_phase_e ph);
    return (ph == PH_G1) || (ph == PH_G2) || (ph == PH_G3);
  endfunction

endpackage

// File: rtl/obs_reset_sync.sv
module obs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/obs_hold_timer.sv
// Counts cycles since the last start and flags the wide interval.
module obs_hold_timer #(
  parameter int WIDE_CYCLES = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run_en,
  output logic wide_active
);
  localparam int CNT_W = $clog2(WIDE_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(WIDE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart || (run_en && (cnt_q != HOLD_END));
    cnt_d  = restart ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign wide_active = (cnt_q < HOLD_END);
endmodule

// File: rtl/obs_window_fsm.sv
// Gain-update window sequencer: G1, G2, optional G3, then FROZEN.
module obs_window_fsm
  import obs_pkg::*;
#(
  parameter int WIN_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       freeze,
  input  logic       level_ok,
  output agc_phase_e phase
);
  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

  agc_phase_e       ph_q, ph_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             win_en;
  logic             win_end;

  assign win_end = (win_q == WIN_LAST);

  always_comb begin
    ph_d   = ph_q;
    win_d  = win_q + WIN_W'(1);
    win_en = 1'b0;
    if (start) begin
      ph_d   = PH_G1;
      win_d  = '0;
      win_en = 1'b1;
    end else if (phase_active(ph_q)) begin
      win_en = 1'b1;
      if (freeze) begin
        ph_d  = PH_FROZEN;
        win_d = '0;
      end else if (win_end) begin
        win_d = '0;
        unique case (ph_q)
          PH_G1:   ph_d = PH_G2;
          PH_G2:   ph_d = level_ok ? PH_FROZEN : PH_G3;
          default: ph_d = PH_FROZEN;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/obs_code_map.sv
module obs_code_map
  import obs_pkg::*;
(
  input  agc_phase_e phase,
  input  logic       wide_active,
  output bw_code_e   code,
  output logic       done
);
  always_comb begin
    unique case (phase)
      PH_G1, PH_G2, PH_G3: code = wide_active ? BW_WIDE : BW_MEDIUM;
      PH_FROZEN:           code = BW_NARROW;
      default:             code = BW_OFF;
    endcase
    done = (phase == PH_FROZEN);
  end
endmodule

// File: rtl/offset_bw_sequencer.sv
module offset_bw_sequencer
  import obs_pkg::*;
#(
  parameter int WIDE_CYCLES = 36,
  parameter int WIN_CYCLES  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       agc_start_i,
  input  logic       agc_freeze_i,
  input  logic       level_ok_i,
  output logic [1:0] bw_code_o,
  output logic [2:0] phase_o,
  output logic       done_o
);
  logic       rst_n_sync;
  agc_phase_e phase;
  logic       wide_active;
  bw_code_e   code;

  obs_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  obs_window_fsm #(.WIN_CYCLES(WIN_CYCLES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .start    (agc_start_i),
    .freeze   (agc_freeze_i),
    .level_ok (level_ok_i),
    .phase    (phase)
  );

  obs_hold_timer #(.WIDE_CYCLES(WIDE_CYCLES)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .restart     (agc_start_i),
    .run_en      (phase_active(phase)),
    .wide_active (wide_active)
  );

  obs_code_map u_map (
    .phase       (phase),
    .wide_active (wide_active),
    .code        (code),
    .done        (done_o)
  );

  assign bw_code_o = code;
  assign phase_o   = phase;
endmodule

// File: rtl/offset_bw_sequencer_chk.sv
module offset_bw_sequencer_chk #(
  parameter int WIDE_CYCLES = 36
) (
  input logic       clk,
  input logic       rst_n,
  input logic       agc_start_i,
  input logic       agc_freeze_i,
  input logic [1:0] bw_code_o,
  input logic [2:0] phase_o,
  input logic       done_o
);
  localparam int RW = $clog2(WIDE_CYCLES + 2);

  logic [RW-1:0] wide_run_q;
  logic          in_window;

  assign in_window = (phase_o == 3'd1) || (phase_o == 3'd2) || (phase_o == 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      wide_run_q <= '0;
    else if (agc_start_i)                            wide_run_q <= '0;
    else if (bw_code_o == 2'b11 && wide_run_q <= RW'(WIDE_CYCLES)) wide_run_q <= wide_run_q + RW'(1);
  end

  // R2
  p_start_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    agc_start_i |=> (phase_o == 3'd1 && bw_code_o == 2'b11));

  // R3: wide code never held longer than the limit since the last start
  p_wide_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_code_o == 2'b11) |-> (wide_run_q < RW'(WIDE_CYCLES)));

  // R4
  p_freeze_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!agc_start_i && agc_freeze_i && in_window) |=> (bw_code_o == 2'b01 && done_o));

  // R8
  p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd4 && !agc_start_i) |=> (phase_o == 3'd4 && bw_code_o == 2'b01));

  // R10
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0 && !agc_start_i) |=> (phase_o == 3'd0 && bw_code_o == 2'b00));

  // R5
  p_g1_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 && !agc_start_i && !agc_freeze_i) |=> (phase_o == 3'd1 || phase_o == 3'd2));
endmodule

bind offset_bw_sequencer offset_bw_sequencer_chk #(.WIDE_CYCLES(WIDE_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .agc_start_i  (agc_start_i),
  .agc_freeze_i (agc_freeze_i),
  .bw_code_o    (bw_code_o),
  .phase_o      (phase_o),
  .done_o       (done_o)
);

// File: tb/offset_bw_sequencer_tb_top.sv
module offset_bw_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIDE = 36;
  localparam int WIN  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, freeze = 1'b0, lvl = 1'b0;
  logic [1:0] code;
  logic [2:0] phase;
  logic       done;

  int checks = 0;
  int failures = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  int mp = 0;
  int mj = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  offset_bw_sequencer #(.WIDE_CYCLES(WIDE), .WIN_CYCLES(WIN)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .agc_start_i (start), .agc_freeze_i (freeze), .level_ok_i (lvl),
    .bw_code_o (code), .phase_o (phase), .done_o (done)
  );

  function automatic logic [1:0] exp_code(input int p, input int j);
    if (p == 0) return 2'b00;
    if (p == 4) return 2'b01;
    return (j < WIDE) ? 2'b11 : 2'b10;
  endfunction

  task automatic check_now(input logic [5:0] e, input string tag);
    logic [5:0] a;
    a = {phase, code, done};
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s phase/code/done actual=%0d/%b/%b expected=%0d/%b/%b",
               tag, a[5:3], a[2:1], a[0], e[5:3], e[2:1], e[0]);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) check_now(exp_q.pop_front(), tag_q.pop_front());
  end

  // driver: applies one cycle of inputs and queues the outputs due after the next edge
  task automatic step(input logic st, input logic fz, input logic lv, input string tag);
    @(negedge clk); #1;
    start = st; freeze = fz; lvl = lv;
    if (st) begin
      mp = 1; mj = 0;
    end else if (mp >= 1 && mp <= 3) begin
      if (fz) mp = 4;
      else if (mp == 2 && mj == 2*WIN-1 && lv) begin mp = 4; mj++; end
      else begin
        mj++;
        mp = (mj < WIN) ? 1 : (mj < 2*WIN) ? 2 : (mj < 3*WIN) ? 3 : 4;
      end
    end
    exp_q.push_back({3'(mp), exp_code(mp, mj), (mp == 4)});
    tag_q.push_back(tag);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_now({3'd0, 2'b00, 1'b0}, "R1");
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (4) step(0, 0, 0, "R1");

    // R10: freeze and level in idle ignored
    repeat (3) step(0, 1, 1, "R10");

    // full run, no level, no freeze
    step(1, 0, 0, "R2");
    for (int j = 1; j < 100; j++)
      step(0, 0, 0, (j <= WIDE) ? "R3" : (j < 3*WIN) ? "R5" : "R7");
    repeat (5) step(0, 1, 1, "R8");

    // level high throughout: G3 skipped
    step(1, 0, 1, "R2");
    for (int j = 1; j < 70; j++) step(0, 0, 1, "R6");

    // start and freeze together, then freeze during wide
    step(1, 1, 0, "R11");
    for (int j = 1; j <= 20; j++) step(0, 0, 0, "R3");
    step(0, 1, 0, "R4");
    repeat (10) step(0, 0, 0, "R8");

    // restart mid-run
    step(1, 0, 0, "R2");
    for (int j = 1; j <= 50; j++) step(0, 0, 0, "R5");
    step(1, 0, 0, "R9");
    for (int j = 1; j <= 40; j++) step(0, 0, 0, "R9");

    step(0, 0, 0, "R5");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule